// File: doc/BRIEF.md
# Ready-Path Skid Buffer

This block sits on a single valid/ready link and cuts the combinational ready path between its two sides. A token moves across an edge on a cycle where valid and ready are both 1. While the internal holding slot is empty, data and valid pass straight through without a register, so the buffer adds no latency. When the downstream side drops ready on a cycle where a token arrives, that token is caught in a single side register and is not lost. The upstream ready comes only from the state of that register, never from the downstream ready.

A designer places one of these wherever a long ready chain limits timing. It is often paired with a separate stage that registers data and valid, but that stage is not part of this block. Reset is synchronous and active high.

Top module: `skid_ready_cut`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the holding slot is empty: `up_ready` is 1 and `dn_valid` equals `up_valid`.
- R2: While the holding slot is empty, `dn_valid` equals `up_valid` and `dn_data` equals `up_data` in the same cycle, with no register on the way.
- R3: `up_ready` is 1 exactly when the holding slot is empty, and changing `dn_ready` within a cycle never changes `up_ready`.
- R4: On a cycle with `up_valid`=1, `up_ready`=1 and `dn_ready`=0, the incoming token is stored. On the next cycle `dn_valid`=1, `dn_data` shows that token and `up_ready`=0.
- R5: While the holding slot is full, `dn_data` shows the stored token, and `up_data` and `up_valid` have no effect on the outputs.
- R6: A stored token leaves on the first cycle `dn_ready` is 1, and `up_ready` returns to 1 on the following cycle.
- R7: Tokens leave in the order they were accepted, each exactly once, under any pattern of `up_valid` and `dn_ready`.
- R8: Changing `dn_ready` within a cycle never changes `dn_valid`, so no combinational path runs from ready to valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up_data | input | W | Incoming token payload |
| up_valid | input | 1 | Incoming token present |
| up_ready | output | 1 | Buffer accepts a token this cycle |
| dn_data | output | W | Outgoing token payload |
| dn_valid | output | 1 | Outgoing token present |
| dn_ready | input | 1 | Downstream accepts a token this cycle |

## Verification
The hardest case to reach is a token caught in the holding slot while the upstream side keeps showing a new token with different data, followed by a release in the very cycle the upstream changes again. The bench sweeps every four-cycle sequence of upstream valid and downstream ready, then runs a long random stall pattern. Whenever its model says the slot is full, it drives junk data on the input. Inside each cycle it also flips the downstream ready and checks that valid and upstream ready do not move.

// File: rtl/skid_ready_cut.sv
module skid_ready_cut #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] up_data,
  input  logic         up_valid,
  output logic         up_ready,
  output logic [W-1:0] dn_data,
  output logic         dn_valid,
  input  logic         dn_ready
);

  logic         held;
  logic [W-1:0] held_data;
  logic         catch_tok;

  assign catch_tok = up_valid & ~held & ~dn_ready;

  always_ff @(posedge clk) begin
    if (rst)            held <= 1'b0;
    else if (catch_tok) held <= 1'b1;
    else if (dn_ready)  held <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (catch_tok) held_data <= up_data;
  end

  assign up_ready = ~held;
  assign dn_valid = held | up_valid;
  assign dn_data  = held ? held_data : up_data;

  // R1
  a_r1_reset_empty: assert property (@(posedge clk) rst |=> up_ready);

  a_r4_catch: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready && !dn_ready) |=>
      (dn_valid && !up_ready && dn_data == $past(up_data)));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (!up_ready && dn_ready) |=> up_ready);

endmodule

// File: tb/skid_ready_cut_bench.sv
`timescale 1ns/100ps
module skid_ready_cut_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] up_data;
  logic         up_valid;
  logic         up_ready;
  logic [W-1:0] dn_data;
  logic         dn_valid;
  logic         dn_ready;

  always #2 clk = ~clk;

  skid_ready_cut #(.W(W)) u_skid_ready_cut (
    .clk(clk), .rst(rst),
    .up_data(up_data), .up_valid(up_valid), .up_ready(up_ready),
    .dn_data(dn_data), .dn_valid(dn_valid), .dn_ready(dn_ready)
  );

  int checks = 0;
  int errors = 0;
  logic         mfull = 1'b0;
  logic [W-1:0] mdata = '0;
  logic [W-1:0] next_tok = 8'd1;
  logic [W-1:0] q[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit iv, input bit rd);
    logic [W-1:0] din;
    logic [W-1:0] sampled;
    bit v0, r0;
    @(negedge clk);
    din = mfull ? W'($urandom) : next_tok;
    up_valid = iv;
    up_data  = din;
    dn_ready = rd;
    #0.5;
    chk(up_ready == !mfull, "R3 up_ready", up_ready, !mfull);
    chk(dn_valid == (mfull | iv), mfull ? "R5 dn_valid" : "R2 dn_valid", dn_valid, mfull | iv);
    if (mfull)   chk(dn_data == mdata, "R5 dn_data", dn_data, mdata);
    else if (iv) chk(dn_data == din, "R2 dn_data", dn_data, din);
    v0 = dn_valid; r0 = up_ready; sampled = dn_data;
    dn_ready = ~rd;
    #0.5;
    chk(dn_valid == v0, "R8 dn_valid vs dn_ready", dn_valid, v0);
    chk(up_ready == r0, "R3 up_ready vs dn_ready", up_ready, r0);
    dn_ready = rd;
    #0.3;
    @(posedge clk);
    if (iv && !mfull) begin
      q.push_back(din);
      next_tok = next_tok + 1'b1;
    end
    if ((mfull || iv) && rd) begin
      if (q.size() == 0) chk(1'b0, "R7 spurious token", sampled, -1);
      else begin
        chk(sampled == q[0], "R7 order", sampled, q[0]);
        void'(q.pop_front());
      end
    end
    if (!mfull && iv && !rd) begin
      mfull = 1'b1;
      mdata = din;
    end else if (mfull && rd) begin
      mfull = 1'b0;
    end
    chk(q.size() <= 1, "R7 no drop", q.size(), 1);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; up_valid = 1'b0; up_data = '0; dn_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(up_ready == 1'b1, "R1 ready in reset", up_ready, 1);
    chk(dn_valid == 1'b0, "R1 valid in reset", dn_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    up_valid = 1'b1;
    #0.5;
    chk(up_ready == 1'b1, "R1 ready after reset", up_ready, 1);
    chk(dn_valid == 1'b1, "R1 valid follows input", dn_valid, 1);
    up_valid = 1'b0;

    // R4 directed catch then R6 release
    step(1'b1, 1'b0);
    @(negedge clk); #0.5;
    chk(dn_valid && !up_ready, "R4 caught", {dn_valid, up_ready}, 2);
    chk(dn_data == q[0], "R4 caught data", dn_data, q[0]);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    @(negedge clk); #0.5;
    chk(up_ready == 1'b1, "R6 ready back", up_ready, 1);

    for (int p = 0; p < 256; p++)
      for (int k = 0; k < 4; k++)
        step(p[2*k], p[2*k+1]);

    for (int i = 0; i < 3000; i++)
      step(1'($urandom), ($urandom % 4) != 0);

    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    chk(q.size() == 0, "R7 drained", q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule